// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Set-Less-Than

This block is a 32-bit integer arithmetic/logic unit. It is built as a row of identical one-bit slices plus a separate top slice. Each slice holds an AND gate, an OR gate, a full adder and a four-way output selector. The slices use only AND, OR, XOR and NOT logic.

A single negate-b line does two jobs. It inverts the b operand in every slice, and it feeds the carry into slice 0. Subtraction is therefore computed as a + ~b + 1. The carry chain between slices is a plain ripple.

For set-less-than, the top slice forms a signed comparison result from its adder output, taken before its selector. That bit is routed to the "less" input of slice 0. The less inputs of all other slices are held at 0. The result word, a zero flag, an overflow flag and the final carry-out are captured in output registers on the rising clock edge. The registers clear under a synchronous active-high reset.

Top module: `alu_slice32`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `result_q`=0, `zero_q`=1, `ovf_q`=0 and `cout_q`=0.
- R2: With `bneg`=0 and `op`=2'b00 the result is the bitwise AND of `a_in` and `b_in`.
- R3: With `bneg`=0 and `op`=2'b01 the result is the bitwise OR of `a_in` and `b_in`.
- R4: With `bneg`=0 and `op`=2'b10 the result is `a_in + b_in` modulo 2^32.
- R5: With `bneg`=1 and `op`=2'b10 the result is `a_in - b_in` modulo 2^32, computed as a + ~b + 1.
- R6: With `bneg`=1 and `op`=2'b11 the result is 1 when `a_in` < `b_in` as two's-complement numbers and 0 otherwise. Bits 31..1 are always 0. The decision stays correct when a - b overflows.
- R7: `ovf_q` is 1 only for `op`=2'b10, and then only when the carry into bit 31 differs from the carry out of bit 31. It is 0 for AND, OR and set-less-than.
- R8: `zero_q` is 1 exactly when all 32 bits of the registered result are 0.
- R9: `cout_q` is the carry out of bit 31 of a + (b XOR {32{bneg}}) + bneg, whatever the op.
- R10: All outputs reflect the inputs present at the previous rising edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| bneg | input | 1 | Inverts b in every slice and is the carry into slice 0 |
| op | input | 2 | Selects the slice output: 00 AND, 01 OR, 10 adder sum, 11 less input |
| result_q | output | 32 | Registered result word |
| zero_q | output | 1 | Registered flag: result is all zeros |
| ovf_q | output | 1 | Registered signed overflow flag of add/subtract |
| cout_q | output | 1 | Registered carry out of the top slice |

## Verification
Every result, flag and carry is due exactly one rising edge after the operands and control are presented. No output has any path that skips the output registers.

The bench changes inputs only on falling edges and keeps a queue of expected values, one entry per applied vector. Each entry is compared at the next falling edge, which is the first point where that vector's registered outputs are settled. A miscounted latency therefore shows up as a mismatch on every vector.

The directed cases include the most negative and most positive values, equal operands, and operand pairs whose difference overflows. These cases pin down the overflow-corrected comparison.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W = 32;

  typedef enum logic [1:0] {
    SEL_AND   = 2'b00,
    SEL_OR    = 2'b01,
    SEL_ARITH = 2'b10,
    SEL_LESS  = 2'b11
  } alu_sel_e;
endpackage

// File: rtl/alu_bit_cell.sv
// One ordinary slice: AND, OR, full adder, four-way selector built from gates.
module alu_bit_cell (
  input  logic       a,
  input  logic       b,
  input  logic       bneg,
  input  logic       cin,
  input  logic       less,
  input  logic [1:0] op,
  output logic       res,
  output logic       cout
);
  logic b_eff, and_o, or_o, half, sum_o;
  logic d_and, d_or, d_sum, d_less;

  always_comb begin
    b_eff  = b ^ bneg;
    and_o  = a & b_eff;
    or_o   = a | b_eff;
    half   = a ^ b_eff;
    sum_o  = half ^ cin;
    cout   = (a & b_eff) | (cin & half);
    d_and  = ~op[1] & ~op[0];
    d_or   = ~op[1] &  op[0];
    d_sum  =  op[1] & ~op[0];
    d_less =  op[1] &  op[0];
    res    = (d_and & and_o) | (d_or & or_o) | (d_sum & sum_o) | (d_less & less);
  end
endmodule

// File: rtl/alu_top_cell.sv
// Most-significant slice: also yields signed overflow and the comparison bit.
module alu_top_cell (
  input  logic       a,
  input  logic       b,
  input  logic       bneg,
  input  logic       cin,
  input  logic       less,
  input  logic [1:0] op,
  output logic       res,
  output logic       cout,
  output logic       set_o,
  output logic       ovf_o
);
  logic b_eff, and_o, or_o, half, sum_o, ovf_raw;
  logic d_and, d_or, d_sum, d_less;

  always_comb begin
    b_eff   = b ^ bneg;
    and_o   = a & b_eff;
    or_o    = a | b_eff;
    half    = a ^ b_eff;
    sum_o   = half ^ cin;
    cout    = (a & b_eff) | (cin & half);
    ovf_raw = cin ^ cout;
    // sign of a-b corrected by overflow gives the true signed order
    set_o   = sum_o ^ ovf_raw;
    d_and   = ~op[1] & ~op[0];
    d_or    = ~op[1] &  op[0];
    d_sum   =  op[1] & ~op[0];
    d_less  =  op[1] &  op[0];
    ovf_o   = ovf_raw & d_sum;
    res     = (d_and & and_o) | (d_or & or_o) | (d_sum & sum_o) | (d_less & less);
  end
endmodule

// File: rtl/alu_zero_nor.sv
// Wide NOR over the result word.
module alu_zero_nor #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] vec,
  output logic         zero_o
);
  always_comb zero_o = ~(|vec);
endmodule

// File: rtl/alu_slice32.sv
module alu_slice32
  import alu_pkg::*;
#(
  parameter int unsigned W = ALU_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         bneg,
  input  logic [1:0]   op,
  output logic [W-1:0] result_q,
  output logic         zero_q,
  output logic         ovf_q,
  output logic         cout_q
);
  localparam int unsigned TOP = W - 1;

  logic [W:0]   carry;
  logic [W-1:0] less_v;
  logic [W-1:0] res_c;
  logic         set_top, ovf_c, zero_c;

  assign carry[0] = bneg;

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      if (i == 0) begin : g_lsb_less
        assign less_v[i] = set_top;
      end else begin : g_tied_less
        assign less_v[i] = 1'b0;
      end

      if (i == TOP) begin : g_top
        alu_top_cell u_cell (
          .a    (a_in[i]),
          .b    (b_in[i]),
          .bneg (bneg),
          .cin  (carry[i]),
          .less (less_v[i]),
          .op   (op),
          .res  (res_c[i]),
          .cout (carry[i+1]),
          .set_o(set_top),
          .ovf_o(ovf_c)
        );
      end else begin : g_mid
        alu_bit_cell u_cell (
          .a    (a_in[i]),
          .b    (b_in[i]),
          .bneg (bneg),
          .cin  (carry[i]),
          .less (less_v[i]),
          .op   (op),
          .res  (res_c[i]),
          .cout (carry[i+1])
        );
      end
    end
  endgenerate

  alu_zero_nor #(.W(W)) u_zero (
    .vec   (res_c),
    .zero_o(zero_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      zero_q   <= 1'b1;
      ovf_q    <= 1'b0;
      cout_q   <= 1'b0;
    end else begin
      result_q <= res_c;
      zero_q   <= zero_c;
      ovf_q    <= ovf_c;
      cout_q   <= carry[W];
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (result_q == '0 && zero_q && !ovf_q && !cout_q)); // R1

  AST_AND_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == SEL_AND && !$past(bneg))
      |-> result_q == ($past(a_in) & $past(b_in))); // R2

  AST_LESS_NARROW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == SEL_LESS && $past(bneg))
      |-> result_q[W-1:1] == '0); // R6

  AST_LESS_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == SEL_LESS && $past(bneg) && $past(a_in) == $past(b_in))
      |-> result_q == '0); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) != SEL_ARITH) |-> !ovf_q); // R7

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    zero_q == (result_q == '0)); // R8
endmodule

// File: tb/alu_slice32_bench.sv
`timescale 1ns/1ps
module alu_slice32_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in;
  logic         bneg;
  logic [1:0]   op;
  logic [W-1:0] result_q;
  logic         zero_q, ovf_q, cout_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [W-1:0] r;
    logic z, v, c;
    string tag;
  } exp_t;
  exp_t pend[$];

  always #2 clk = ~clk;

  alu_slice32 #(.W(W)) u_alu_slice32 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .bneg(bneg), .op(op),
    .result_q(result_q), .zero_q(zero_q), .ovf_q(ovf_q), .cout_q(cout_q)
  );

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic bn, input logic [1:0] o);
    exp_t e;
    logic [W:0] s;
    logic [W-1:0] bb;
    bb = bn ? ~b : b;
    s  = {1'b0, a} + {1'b0, bb} + (W+1)'(bn);
    e.c = s[W];
    e.v = 1'b0;
    case (o)
      2'b00: begin e.r = a & b; e.tag = "R2 R8 R9 R10"; end
      2'b01: begin e.r = a | b; e.tag = "R3 R8 R9 R10"; end
      2'b10: begin
        e.r = s[W-1:0];
        e.v = (a[W-1] == bb[W-1]) && (s[W-1] != a[W-1]);
        e.tag = bn ? "R5 R7 R8 R9 R10" : "R4 R7 R8 R9 R10";
      end
      default: begin
        e.r = ($signed(a) < $signed(b)) ? W'(1) : W'(0);
        e.tag = "R6 R7 R9 R10";
      end
    endcase
    e.z = (e.r == '0);
    return e;
  endfunction

  task automatic compare();
    exp_t e;
    e = pend.pop_front();
    checks++;
    if (result_q !== e.r || zero_q !== e.z || ovf_q !== e.v || cout_q !== e.c) begin
      failures++;
      $display("FAIL %s: res=%h z=%b v=%b c=%b expected res=%h z=%b v=%b c=%b",
               e.tag, result_q, zero_q, ovf_q, cout_q, e.r, e.z, e.v, e.c);
    end
  endtask

  // drive on a falling edge, compare at the next falling edge
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic bn, input logic [1:0] o);
    a_in = a; b_in = b; bneg = bn; op = o;
    pend.push_back(model(a, b, bn, o));
    @(negedge clk);
    compare();
  endtask

  task automatic slt(input logic [W-1:0] a, input logic [W-1:0] b);
    step(a, b, 1'b1, 2'b11);
  endtask

  function automatic logic [W-1:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    rst = 1'b1; a_in = 32'hDEAD_BEEF; b_in = 32'h1234_5678; bneg = 1'b1; op = 2'b10;
    repeat (3) @(negedge clk);
    checks++;
    if (result_q !== '0 || zero_q !== 1'b1 || ovf_q !== 1'b0 || cout_q !== 1'b0) begin
      failures++;
      $display("FAIL R1: res=%h z=%b v=%b c=%b expected res=0 z=1 v=0 c=0",
               result_q, zero_q, ovf_q, cout_q);
    end
    rst = 1'b0;

    step(32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 2'b00);   // R2
    step(32'h0000_00FF, 32'hFFFF_FF00, 1'b0, 2'b00);   // R2 zero result, R8
    step(32'hF0F0_0000, 32'h0F0F_0001, 1'b0, 2'b01);   // R3
    step(32'h0000_0000, 32'h0000_0000, 1'b0, 2'b01);   // R3 R8
    step(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 2'b10);   // R4 R7 overflow
    step(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 2'b10);   // R4 R9 carry, zero
    step(32'h8000_0000, 32'h8000_0000, 1'b0, 2'b10);   // R4 R7 neg overflow
    step(32'h8000_0000, 32'h0000_0001, 1'b1, 2'b10);   // R5 R7 overflow
    step(32'h1234_5678, 32'h1234_5678, 1'b1, 2'b10);   // R5 R8 zero
    step(32'h0000_0003, 32'h0000_0005, 1'b1, 2'b10);   // R5 borrow
    slt(32'h8000_0000, 32'h7FFF_FFFF);                 // R6 overflow pair -> 1
    slt(32'h7FFF_FFFF, 32'h8000_0000);                 // R6 overflow pair -> 0
    slt(32'hFFFF_FFFD, 32'h0000_0002);                 // R6 -3 < 2
    slt(32'h0000_0002, 32'hFFFF_FFFD);                 // R6
    slt(32'h5555_5555, 32'h5555_5555);                 // R6 equal -> 0
    slt(32'h8000_0000, 32'h8000_0000);                 // R6 equal min
    slt(32'hFFFF_FFFF, 32'h0000_0000);                 // R6 -1 < 0

    for (int k = 0; k < 3000; k++) begin
      int sel;
      sel = $urandom_range(0, 4);
      case (sel)
        0: step(pick(), pick(), 1'b0, 2'b00);
        1: step(pick(), pick(), 1'b0, 2'b01);
        2: step(pick(), pick(), 1'b0, 2'b10);
        3: step(pick(), pick(), 1'b1, 2'b10);
        default: slt(pick(), pick());
      endcase
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule